// File: doc/BRIEF.md
# Shared Interrupt Line Port

This block sits on each adapter that shares one open-collector interrupt line with other adapters. The adapter's own function raises a level-sensitive request. The block turns that request into a short low-going pulse on the shared line. The line idles high through an external pull-up. The falling edge of the pulse arms the host interrupt controller, and the rising edge at the end of the pulse fires the interrupt. The block never holds the line low. The pin itself is modelled as an output-enable, and the driven value is tied to zero.

Every adapter on the line watches it. Once any pulse appears, whether from this adapter or another one, the block locks out further pulses. It stays locked until the host performs a global rearm. A rearm is an I/O write to address 0x2F0 plus the configured interrupt level. If this adapter's request is still active when the rearm arrives, the block pulses again, so that a request made at the same moment as another adapter's is not lost. A software enable keeps the adapter quiet. A status bit tells the handler whether this adapter is requesting.

Top module: `shirq_port`

## Requirements
- R1: After reset, `line_oe` and `stat_req` are low and `line_o` is 0. The block is armed, so a request seen on the first clock edge starts a pulse in the next cycle.
- R2: When the block is armed with `dev_req` and `irq_en` both high and no outside pulse sensed, `line_oe` rises in the cycle after that edge. It stays high for exactly PULSE_W cycles (default 4). `line_o` is always 0.
- R3: After its own pulse, the block starts no further pulse while `dev_req` stays high, until a rearm arrives.
- R4: A low level on `line_i` that the block is not driving locks the block out. Its first sync stage samples the level, and after SYNC_STAGES clock edges it blocks later requests until a rearm.
- R5: A rearm is a cycle with `io_wr` high and `io_addr` equal to 0x2F0 + `irq_level`, and only for `irq_level` from 2 to 7. Any other address, a cycle with `io_wr` low, or a level of 0 or 1 has no effect.
- R6: A rearm seen while locked returns the block to armed on that edge. If `dev_req` is still high, a new pulse starts one cycle later, so `line_oe` rises two cycles after the strobe cycle.
- R7: A rearm that arrives during a pulse is kept. The pulse still runs its full width. The block then goes armed and, if `dev_req` is high, pulses again after one idle cycle.
- R8: The block ignores the echo of its own pulse through the synchronizer for SYNC_STAGES cycles after it releases the line. An armed block stays armed after its own pulse.
- R9: While `irq_en` is low, no pulse begins and the request is kept. Raising `irq_en` while armed with `dev_req` high starts a pulse in the next cycle.
- R10: `stat_req` equals `dev_req` delayed by one clock, whatever the value of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_level | input | 3 | Interrupt level this adapter shares (2 to 7 valid) |
| io_addr | input | 10 | Host I/O address |
| io_wr | input | 1 | One-cycle I/O write strobe |
| dev_req | input | 1 | Level request from the adapter's function |
| irq_en | input | 1 | Software enable for pulsing |
| line_i | input | 1 | Sensed level of the shared interrupt line |
| line_oe | output | 1 | Pull the shared line low when high |
| line_o | output | 1 | Value driven when enabled, always 0 |
| stat_req | output | 1 | Status bit: this adapter is requesting |

## Verification
A block stuck in the locked state shows as a missing pulse on `line_oe`. That becomes visible two cycles after a rearm strobe while a request is held. A block wrongly left armed shows as an extra pulse the cycle after any request that follows a pulse. A lost mid-pulse rearm or an unmasked self-echo shows as a missing second pulse, PULSE_W + 1 cycles after the first one starts. A scoreboard compares every pulse's start cycle and width against the expected ones, so any shift of even one cycle is reported.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_PULSING = 2'd1,
    ST_LOCKED  = 2'd2
  } shirq_state_e;

  localparam int unsigned ADDR_W = 10;
  localparam int unsigned LVL_W  = 3;
  localparam logic [ADDR_W-1:0] REARM_BASE = 10'h2F0;
  localparam logic [LVL_W-1:0]  LVL_MIN    = 3'd2;
endpackage

// File: rtl/shirq_sync.sv
module shirq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/shirq_rearm_dec.sv
module shirq_rearm_dec
  import shirq_pkg::*;
(
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [LVL_W-1:0]  level,
  output logic              rearm_hit
);
  logic [ADDR_W-1:0] target;
  logic              level_ok;

  always_comb begin
    target    = REARM_BASE + ADDR_W'(level);
    level_ok  = (level >= LVL_MIN);
    rearm_hit = io_wr && level_ok && (io_addr == target);
  end
endmodule

// File: rtl/shirq_fsm.sv
module shirq_fsm
  import shirq_pkg::*;
#(
  parameter int unsigned PULSE_W = 4,
  parameter int unsigned BLANK   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic en,
  input  logic line_sync,
  input  logic rearm_hit,
  output logic line_oe
);
  localparam int unsigned CNT_W   = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
  localparam int unsigned BLANK_W = $clog2(BLANK + 1);
  localparam logic [CNT_W-1:0]   CNT_LAST  = CNT_W'(PULSE_W - 1);
  localparam logic [BLANK_W-1:0] BLANK_MAX = BLANK_W'(BLANK);

  shirq_state_e        state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BLANK_W-1:0]  blank_q, blank_d;
  logic                pend_q, pend_d;
  logic                blank_en, ext_low, pulse_last;

  always_comb begin
    ext_low    = !line_sync && (blank_q == '0) && (state_q != ST_PULSING);
    pulse_last = (cnt_q == CNT_LAST);
    state_d    = state_q;
    cnt_d      = cnt_q;
    pend_d     = pend_q;
    unique case (state_q)
      ST_ARMED: begin
        if (ext_low) begin
          state_d = ST_LOCKED;
        end else if (req && en) begin
          state_d = ST_PULSING;
          cnt_d   = '0;
          pend_d  = 1'b0;
        end
      end
      ST_PULSING: begin
        if (pulse_last) begin
          state_d = (pend_q || rearm_hit) ? ST_ARMED : ST_LOCKED;
          cnt_d   = '0;
          pend_d  = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
          if (rearm_hit) pend_d = 1'b1;
        end
      end
      ST_LOCKED: begin
        if (rearm_hit) state_d = ST_ARMED;
      end
      default: state_d = ST_ARMED;
    endcase
  end

  always_comb begin
    blank_en = (state_q == ST_PULSING) || (blank_q != '0);
    blank_d  = (state_q == ST_PULSING) ? BLANK_MAX : blank_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        blank_q <= '0;
    else if (blank_en) blank_q <= blank_d;
  end

  assign line_oe = (state_q == ST_PULSING);

  // R2: a pulse ends only after the full width has been counted
  p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> ($past(cnt_q) == CNT_LAST));

  // R3: a locked block stays silent until a rearm
  p_lock_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED && !rearm_hit) |=> !line_oe);

  // R4: an outside pulse seen while armed locks the block
  p_ext_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && !line_sync && blank_q == '0) |=> (state_q == ST_LOCKED));

  // R6: a rearm releases the lockout on the same edge
  p_rearm_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED && rearm_hit) |=> (state_q == ST_ARMED));

  // R9: a pulse only begins on an enabled request
  p_start_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $past(req && en));
endmodule

// File: rtl/shirq_port.sv
module shirq_port
  import shirq_pkg::*;
#(
  parameter int unsigned PULSE_W     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              dev_req,
  input  logic              irq_en,
  input  logic              line_i,
  output logic              line_oe,
  output logic              line_o,
  output logic              stat_req
);
  logic rst_sync_n, line_sync, rearm_hit, stat_q;

  shirq_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  shirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk), .arst_n(rst_sync_n), .d(line_i), .q(line_sync)
  );

  shirq_rearm_dec u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .level(irq_level), .rearm_hit(rearm_hit)
  );

  shirq_fsm #(.PULSE_W(PULSE_W), .BLANK(SYNC_STAGES)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .req(dev_req), .en(irq_en),
    .line_sync(line_sync), .rearm_hit(rearm_hit), .line_oe(line_oe)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) stat_q <= 1'b0;
    else             stat_q <= dev_req;
  end

  assign stat_req = stat_q;
  assign line_o   = 1'b0;

  // R10: status bit is the request one clock late
  p_status_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stat_req == $past(dev_req));
endmodule

// File: tb/shirq_port_tb.sv
module shirq_port_tb;
  localparam int PW = 4;

  typedef struct { int start; int width; string tag; } pulse_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] irq_level = 3'd2;
  logic [9:0] io_addr = '0;
  logic       io_wr = 1'b0, dev_req = 1'b0, irq_en = 1'b1, ext_pull = 1'b0;
  logic       line_i, line_oe, line_o, stat_req;

  int checks = 0, errors = 0, cyc = 0;
  pulse_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign line_i = ~(line_oe | ext_pull);

  shirq_port #(.PULSE_W(PW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .io_addr(io_addr),
    .io_wr(io_wr), .dev_req(dev_req), .irq_en(irq_en), .line_i(line_i),
    .line_oe(line_oe), .line_o(line_o), .stat_req(stat_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_pulse(input int start, input string tag);
    pulse_t p;
    p.start = start; p.width = PW; p.tag = tag;
    exp_q.push_back(p);
  endtask

  task automatic rearm(input logic [9:0] addr);
    io_addr = addr; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: measures every pulse and compares it with the queue head
  logic prev_oe = 1'b0;
  int   seen_start = 0, seen_w = 0;
  always @(negedge clk) begin
    if (line_o !== 1'b0) begin
      errors++;
      $display("FAIL R2 line_o actual=%0d expected=0", line_o);
    end
    if (line_oe && !prev_oe) begin
      seen_start = cyc; seen_w = 1;
    end else if (line_oe) begin
      seen_w++;
    end else if (prev_oe) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected pulse at %0d actual=1 expected=0", seen_start);
      end else begin
        pulse_t p;
        p = exp_q.pop_front();
        chk({p.tag, " start"}, seen_start, p.start);
        chk({p.tag, " width"}, seen_w, p.width);
      end
    end
    prev_oe = line_oe;
  end

  initial begin
    int c;
    int s;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R1 reset state
    chk("R1 line_oe", line_oe, 0);
    chk("R1 stat_req", stat_req, 0);
    chk("R1 line_o", line_o, 0);

    // R2 first pulse, R3 no repeat while held
    c = cyc; expect_pulse(c + 1, "R2 first");
    dev_req = 1'b1;
    idle(PW + 25);
    chk("R10 stat_req high", stat_req, 1);

    // R5 wrong address, level 2, and address without strobe
    rearm(10'h2F3);
    io_addr = 10'h2F2; idle(12);
    // R6 good rearm with request held
    c = cyc; expect_pulse(c + 2, "R6 repulse");
    rearm(10'h2F2);
    idle(PW + 10);

    // rearm with request low: armed, silent; later request pulses
    dev_req = 1'b0;
    rearm(10'h2F2);
    idle(10);
    c = cyc; expect_pulse(c + 1, "R2 after idle rearm");
    dev_req = 1'b1;
    idle(PW + 10);

    // R7 rearm during the pulse, request still high
    c = cyc; s = c + 2;
    expect_pulse(s, "R7 first");
    expect_pulse(s + PW + 1, "R7 resumed");
    rearm(10'h2F2);
    while (cyc != s + 1) @(negedge clk);
    rearm(10'h2F2);
    idle(2 * PW + 15);

    // R8 rearm during the pulse with request dropped: echo must not lock
    c = cyc; s = c + 2;
    expect_pulse(s, "R8 pulse");
    rearm(10'h2F2);
    while (cyc != s + 1) @(negedge clk);
    dev_req = 1'b0;
    rearm(10'h2F2);
    idle(PW + 10);
    c = cyc; expect_pulse(c + 1, "R8 armed after echo");
    dev_req = 1'b1;
    idle(PW + 10);

    // R4 outside pulse locks an armed block
    dev_req = 1'b0;
    rearm(10'h2F2);
    idle(5);
    ext_pull = 1'b1; idle(4); ext_pull = 1'b0;
    idle(10);
    dev_req = 1'b1;
    idle(15);
    c = cyc; expect_pulse(c + 2, "R4 rearm after lock");
    rearm(10'h2F2);
    idle(PW + 10);

    // R9 enable low holds the request
    dev_req = 1'b0;
    rearm(10'h2F2);
    idle(3);
    irq_en = 1'b0; dev_req = 1'b1;
    idle(15);
    chk("R10 stat_req with enable low", stat_req, 1);
    c = cyc; expect_pulse(c + 1, "R9 enable rise");
    irq_en = 1'b1;
    idle(PW + 10);

    // R5 level selection
    irq_level = 3'd7;
    rearm(10'h2F2);
    idle(10);
    c = cyc; expect_pulse(c + 2, "R5 level 7");
    rearm(10'h2F7);
    idle(PW + 10);
    irq_level = 3'd1;
    rearm(10'h2F1);
    idle(10);
    irq_level = 3'd0;
    rearm(10'h2F0);
    idle(10);
    irq_level = 3'd3;
    c = cyc; expect_pulse(c + 2, "R5 level 3");
    rearm(10'h2F3);
    idle(PW + 20);

    chk("R3 pending pulses left", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule